// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether an I2C target should acknowledge an address byte. A bit-level shifter hands it each received byte together with a one-cycle strobe. It also gives a flag that marks the first byte after a START or repeated START, and a pulse for each STOP condition. The matcher compares the byte against a 10-bit own address, under a per-bit don't-care mask. One cycle after the strobe it returns an ACK/NACK decision, so the shifter can drive SDA during the ninth clock.

The matcher supports two addressing modes. In the 7-bit mode a single byte carries the address and the R/W bit. In the 10-bit mode a header byte (prefix `11110`, the two top address bits, then R/W) is followed by a low address byte. A later repeated START with the read header is accepted only after a complete 10-bit write match in the same transaction. In 7-bit mode, an optional strict setting refuses the reserved address codes, and it takes precedence over the mask. A general-call byte is accepted when general call is enabled, in either mode, and the matcher then raises a status flag for it.

The outputs also include an "addressed" flag and the transfer direction. Bit sampling, the data phase and clock stretching belong to neighbouring blocks.

Top module: `i2cAddrMatch`

## Requirements
- R1: `ackValid` is high for exactly one cycle, on the cycle after the `byteValid` strobe of an address byte. An address byte is any byte with `firstByte` = 1, or the byte that follows an accepted 10-bit write header. `ackOut` = 1 means ACK and 0 means NACK. Any other byte produces no decision and leaves the flags unchanged.
- R2: In 7-bit mode (`tenBitMode` = 0), bits [7:1] of the byte are compared with `ownAddr[6:0]`. Bit 0 is R/W, with 1 meaning read. On a match, `addressed` = 1 and `readDir` follows R/W.
- R3: An `addrMask` bit set to 1 makes the matching own-address bit a don't-care. This applies to the 7-bit compare, to the two header address bits (`addrMask[9:8]`) and to the low byte (`addrMask[7:0]`).
- R4: In 10-bit mode, a first byte of the form `11110`, `ownAddr[9:8]`, 0 is ACKed without setting `addressed`. The next byte is then compared with `ownAddr[7:0]`. A match ACKs and sets `addressed` with `readDir` = 0, and a mismatch NACKs.
- R5: In 10-bit mode, a first byte of the form `11110`, `ownAddr[9:8]`, 1 is ACKed, with `addressed` = 1 and `readDir` = 1, only when a full 10-bit write match has happened since the last STOP or NACK. Otherwise it is NACKed.
- R6: In 7-bit mode with `strictEn` = 1, the 7-bit codes 0x00–0x07 and 0x78–0x7F are never ACKed, whatever the mask says. The only exception is the general call under R7. Codes 0x08–0x77 still match normally.
- R7: Byte 0x00 (general call) is ACKed only when `gcEn` = 1, in either mode and even in strict mode. It then sets both `gcStat` and `addressed`. When `gcEn` = 0 it is never ACKed. Any later accepted non-general-call address clears `gcStat`.
- R8: A `stopDet` pulse clears `addressed`, `gcStat` and `readDir` and forgets any 10-bit match. If a byte strobe arrives in the same cycle as the STOP, the byte is ignored.
- R9: A NACKed address byte clears `addressed`, `gcStat` and `readDir`.
- R10: After reset all outputs are 0.
- R11: In 10-bit mode, a first byte that is neither a matching header nor a general call is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | One-cycle strobe: a received byte is on `byteData` |
| byteData | input | 8 | Received byte, MSB first on the wire, bit 0 = R/W for address bytes |
| firstByte | input | 1 | The strobed byte is the first after START or repeated START |
| stopDet | input | 1 | One-cycle pulse on a STOP condition |
| ownAddr | input | 10 | Own slave address |
| addrMask | input | 10 | Per-bit don't-care mask (1 = ignore bit) |
| tenBitMode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| strictEn | input | 1 | Reject reserved 7-bit codes |
| gcEn | input | 1 | Accept the general call |
| ackValid | output | 1 | Decision valid this cycle |
| ackOut | output | 1 | 1 = ACK, 0 = NACK (meaningful with `ackValid`) |
| addressed | output | 1 | This target has been addressed in the current transaction |
| readDir | output | 1 | Direction of the accepted address, 1 = read |
| gcStat | output | 1 | The accepted address was the general call |

## Verification
The bench probes the reserved-code edges: 0x07, 0x08, 0x77 and 0x78 with a mask that cares about nothing. A design that applied the mask before the strict check would ACK the reserved codes there. It also replays the 10-bit read header in four situations: after a full write match, after a STOP, after a failed low byte, and after a STOP that coincided with a byte strobe. A matcher that did not track the earlier write match would ACK the read header after a STOP. Other cases send general calls with the enable off and with strict mode on, and masked header bits. They also send data bytes that must produce no decision. These catch a matcher that leaks the general call through the mask, or that answers data bytes.

// File: rtl/i2cAddrPkg.sv
package i2cAddrPkg;
  // Byte and address geometry of the bus
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 10;
  localparam int SHORT_W  = BYTE_W - 1;            // 7-bit address width
  localparam int HI_W     = ADDR_W - BYTE_W;       // address bits carried in the 10-bit header
  localparam int PREFIX_W = BYTE_W - HI_W - 1;     // fixed header prefix width
  localparam logic [PREFIX_W-1:0] HDR_PREFIX = 5'b11110;
  localparam int GRP_W    = 4;                     // top bits of a 7-bit code that select reserved groups

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;

  // Compare results from the datapath decoder
  typedef struct packed {
    logic gcHit;      // general call, enabled
    logic hit7;       // 7-bit own-address hit after mask and strict filtering
    logic isPrefix;   // byte carries the 10-bit header prefix (10-bit mode)
    logic prefixHit;  // header prefix with matching top address bits
    logic lowHit;     // byte equals the low 8 address bits under mask
    logic rw;         // R/W bit of the byte
  } matchInfo_t;

  // Strobes from control to the output register stage
  typedef struct packed {
    logic decide;
    logic ack;
    logic setAddr;
    logic clrAll;
    logic setGc;
    logic rd;
  } ctlStrobe_t;
endpackage

// File: rtl/i2cAddrDecode.sv
module i2cAddrDecode
  import i2cAddrPkg::*;
(
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              tenBitMode,
  input  logic              strictEn,
  input  logic              gcEn,
  output matchInfo_t        info
);
  logic [SHORT_W-1:0] rx7;
  logic [SHORT_W-1:0] eq7;
  logic [BYTE_W-1:0]  eqLow;
  logic [HI_W-1:0]    eqHi;
  logic [GRP_W-1:0]   grp;
  logic               isGcCode;
  logic               reservedCode;

  assign rx7 = rxByte[BYTE_W-1:1];
  assign grp = rx7[SHORT_W-1 -: GRP_W];

  // Per-bit compare with don't-care
  for (genvar gi = 0; gi < SHORT_W; gi++) begin : g_eq7
    assign eq7[gi] = (rx7[gi] == ownAddr[gi]) | addrMask[gi];
  end
  for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_eqLow
    assign eqLow[gi] = (rxByte[gi] == ownAddr[gi]) | addrMask[gi];
  end
  for (genvar gi = 0; gi < HI_W; gi++) begin : g_eqHi
    assign eqHi[gi] = (rxByte[gi+1] == ownAddr[BYTE_W+gi]) | addrMask[BYTE_W+gi];
  end

  // Reserved groups: 0000xxx and 1111xxx
  assign reservedCode = (grp == '0) || (grp == '1);
  assign isGcCode     = (rxByte == '0);

  always_comb begin
    info           = '0;
    info.rw        = rxByte[0];
    info.gcHit     = gcEn & isGcCode;
    info.hit7      = !tenBitMode && (&eq7) && !isGcCode && !(strictEn && reservedCode);
    info.isPrefix  = tenBitMode && (rxByte[BYTE_W-1 -: PREFIX_W] == HDR_PREFIX);
    info.prefixHit = info.isPrefix && (&eqHi);
    info.lowHit    = &eqLow;
  end
endmodule

// File: rtl/i2cAddrCtrl.sv
module i2cAddrCtrl
  import i2cAddrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       firstByte,
  input  logic       stopDet,
  input  matchInfo_t info,
  output ctlStrobe_t ctl
);
  phase_e phase, phaseNxt;
  logic   tenDone, tenDoneNxt;

  always_comb begin
    ctl        = '0;
    phaseNxt   = phase;
    tenDoneNxt = tenDone;
    if (stopDet) begin
      ctl.clrAll = 1'b1;
      phaseNxt   = PH_IDLE;
      tenDoneNxt = 1'b0;
    end else if (byteValid && firstByte) begin
      ctl.decide = 1'b1;
      phaseNxt   = PH_IDLE;
      if (info.gcHit) begin
        ctl.ack     = 1'b1;
        ctl.setAddr = 1'b1;
        ctl.setGc   = 1'b1;
        tenDoneNxt  = 1'b0;
      end else if (info.prefixHit && !info.rw) begin
        ctl.ack    = 1'b1;
        ctl.clrAll = 1'b1;
        phaseNxt   = PH_LOW;
        tenDoneNxt = 1'b0;
      end else if (info.prefixHit && info.rw && tenDone) begin
        ctl.ack     = 1'b1;
        ctl.setAddr = 1'b1;
        ctl.rd      = 1'b1;
      end else if (info.hit7) begin
        ctl.ack     = 1'b1;
        ctl.setAddr = 1'b1;
        ctl.rd      = info.rw;
        tenDoneNxt  = 1'b0;
      end else begin
        ctl.clrAll = 1'b1;
        tenDoneNxt = 1'b0;
      end
    end else if (byteValid && phase == PH_LOW) begin
      ctl.decide = 1'b1;
      phaseNxt   = PH_IDLE;
      if (info.lowHit) begin
        ctl.ack     = 1'b1;
        ctl.setAddr = 1'b1;
        tenDoneNxt  = 1'b1;
      end else begin
        ctl.clrAll = 1'b1;
        tenDoneNxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tenDone <= 1'b0;
    end else begin
      phase   <= phaseNxt;
      tenDone <= tenDoneNxt;
    end
  end

  // R5
  read_hdr_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setAddr && ctl.rd && info.isPrefix) |-> tenDone);

  // R4
  low_wait_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LOW) |-> !tenDone);
endmodule

// File: rtl/i2cAddrRegs.sv
module i2cAddrRegs
  import i2cAddrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output logic       ackValid,
  output logic       ackOut,
  output logic       addressed,
  output logic       gcStat,
  output logic       readDir
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackOut    <= 1'b0;
      addressed <= 1'b0;
      gcStat    <= 1'b0;
      readDir   <= 1'b0;
    end else begin
      ackValid <= ctl.decide;
      ackOut   <= ctl.decide & ctl.ack;
      if (ctl.clrAll) begin
        addressed <= 1'b0;
        gcStat    <= 1'b0;
        readDir   <= 1'b0;
      end else if (ctl.setAddr) begin
        addressed <= 1'b1;
        gcStat    <= ctl.setGc;
        readDir   <= ctl.rd;
      end
    end
  end

  // R7
  gc_implies_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    gcStat |-> addressed);

  // R1
  ack_within_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> ackValid);
endmodule

// File: rtl/i2cAddrMatch.sv
module i2cAddrMatch
  import i2cAddrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              firstByte,
  input  logic              stopDet,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              tenBitMode,
  input  logic              strictEn,
  input  logic              gcEn,
  output logic              ackValid,
  output logic              ackOut,
  output logic              addressed,
  output logic              readDir,
  output logic              gcStat
);
  matchInfo_t info;
  ctlStrobe_t ctl;

  i2cAddrDecode uDecode (
    .rxByte     (byteData),
    .ownAddr    (ownAddr),
    .addrMask   (addrMask),
    .tenBitMode (tenBitMode),
    .strictEn   (strictEn),
    .gcEn       (gcEn),
    .info       (info)
  );

  i2cAddrCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .firstByte (firstByte),
    .stopDet   (stopDet),
    .info      (info),
    .ctl       (ctl)
  );

  i2cAddrRegs uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .ackValid  (ackValid),
    .ackOut    (ackOut),
    .addressed (addressed),
    .gcStat    (gcStat),
    .readDir   (readDir)
  );

  // R1
  decision_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteValid));

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> (!addressed && !gcStat && !ackValid));

  // R6
  strict_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackOut && $past(firstByte) && $past(strictEn) && !$past(tenBitMode)
      && ($past(byteData) != '0))
    |-> (($past(byteData[7:4]) != 4'h0) && ($past(byteData[7:4]) != 4'hF)));

  // R7
  gc_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && $past(firstByte) && ($past(byteData) == '0) && !$past(gcEn))
    |-> !ackOut);
endmodule

// File: tb/sim_i2cAddrMatch.sv
`timescale 1ns/1ps
module sim_i2cAddrMatch;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       firstByte = 1'b0;
  logic       stopDet = 1'b0;
  logic [9:0] ownAddr = '0;
  logic [9:0] addrMask = '0;
  logic       tenBitMode = 1'b0;
  logic       strictEn = 1'b0;
  logic       gcEn = 1'b0;
  logic       ackValid, ackOut, addressed, readDir, gcStat;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] v;   // {ack, addressed, gcStat, readDir}
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  i2cAddrMatch u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .firstByte(firstByte), .stopDet(stopDet), .ownAddr(ownAddr),
    .addrMask(addrMask), .tenBitMode(tenBitMode), .strictEn(strictEn),
    .gcEn(gcEn), .ackValid(ackValid), .ackOut(ackOut), .addressed(addressed),
    .readDir(readDir), .gcStat(gcStat)
  );

  // Monitor: pops the scoreboard whenever a decision appears
  always @(negedge clk) begin
    if (rstN && ackValid) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R1: unexpected decision, act ack=%0b exp none", ackOut);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if ({ackOut, addressed, gcStat, readDir} !== it.v) begin
          mismatched++;
          $display("FAIL %s: act {ack,addr,gc,rd}=%b exp %b", it.tag,
                   {ackOut, addressed, gcStat, readDir}, it.v);
        end
      end
    end
  end

  task automatic check(input logic cond, input string tag, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (!cond) begin
      mismatched++;
      $display("FAIL %s: act %b exp %b", tag, act, exp);
    end
  endtask

  // Driver: one byte strobe; a decision is pushed as expected when dec is set
  task automatic sendByte(input logic [7:0] d, input logic first, input logic dec,
                          input logic [3:0] exp, input string tag);
    @(negedge clk);
    if (dec) expQ.push_back('{v: exp, tag: tag});
    byteData  = d;
    firstByte = first;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    firstByte = 1'b0;
  endtask

  task automatic stopPulse();
    @(negedge clk);
    stopDet = 1'b1;
    @(negedge clk);
    stopDet = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: act running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    ownAddr = 10'h052;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check({ackValid, ackOut, addressed, gcStat, readDir} == 5'b0, "R10",
          {ackOut, addressed, gcStat, readDir}, 4'b0000);

    // 7-bit mode, own 0x52
    sendByte(8'hA4, 1, 1, 4'b1100, "R2 write match");
    sendByte(8'h33, 0, 0, 4'b0000, "R1");
    check(addressed === 1'b1, "R1 data byte leaves flags", {3'b0, addressed}, 4'b0001);
    sendByte(8'hA5, 1, 1, 4'b1101, "R2 read match");
    sendByte(8'hA6, 1, 1, 4'b0000, "R9 mismatch clears");

    // R3 mask
    addrMask = 10'h003;
    sendByte(8'hA6, 1, 1, 4'b1100, "R3 masked bit0");
    sendByte(8'hA2, 1, 1, 4'b1100, "R3 masked bit1");
    sendByte(8'hAC, 1, 1, 4'b0000, "R3 unmasked bit2");
    sendByte(8'hA4, 1, 1, 4'b1100, "R2");
    stopPulse();
    check(addressed === 1'b0, "R8 stop clears addressed", {3'b0, addressed}, 4'b0000);

    // R6 strict versus mask
    addrMask = 10'h07F;
    sendByte(8'h02, 1, 1, 4'b1100, "R3 reserved code matches when not strict");
    strictEn = 1'b1;
    sendByte(8'h02, 1, 1, 4'b0000, "R6 0x01 rejected");
    sendByte(8'hF1, 1, 1, 4'b0000, "R6 0x78 rejected");
    sendByte(8'h10, 1, 1, 4'b1100, "R6 0x08 valid");
    sendByte(8'hEE, 1, 1, 4'b1100, "R6 0x77 valid");
    sendByte(8'h0F, 1, 1, 4'b0000, "R6 0x07 rejected");

    // R7 general call
    sendByte(8'h00, 1, 1, 4'b0000, "R7 gc disabled");
    gcEn = 1'b1;
    sendByte(8'h00, 1, 1, 4'b1110, "R7 gc in strict");
    sendByte(8'hA4, 1, 1, 4'b1100, "R7 gc flag cleared by own match");
    sendByte(8'h00, 1, 1, 4'b1110, "R7 gc again");
    stopPulse();
    check({addressed, gcStat} === 2'b00, "R8 stop clears gc", {2'b0, addressed, gcStat}, 4'b0000);
    sendByte(8'h01, 1, 1, 4'b0000, "R6 start byte rejected");

    // 10-bit mode, own 0x2C5
    tenBitMode = 1'b1;
    strictEn   = 1'b0;
    ownAddr    = 10'h2C5;
    addrMask   = 10'h000;
    sendByte(8'hF4, 1, 1, 4'b1000, "R4 header write");
    sendByte(8'hC5, 0, 1, 4'b1100, "R4 low byte match");
    sendByte(8'h11, 0, 0, 4'b0000, "R1");
    sendByte(8'hF5, 1, 1, 4'b1101, "R5 read after full match");
    stopPulse();
    sendByte(8'hF5, 1, 1, 4'b0000, "R5 read after stop");
    sendByte(8'hF4, 1, 1, 4'b1000, "R4 header write");
    sendByte(8'hC4, 0, 1, 4'b0000, "R4 low byte mismatch");
    sendByte(8'hF5, 1, 1, 4'b0000, "R5 read after failed low");
    sendByte(8'hF2, 1, 1, 4'b0000, "R4 wrong top bits");
    addrMask = 10'h300;
    sendByte(8'hF2, 1, 1, 4'b1000, "R3 masked top bits");
    sendByte(8'hC5, 0, 1, 4'b1100, "R3 low after masked header");
    addrMask = 10'h000;
    sendByte(8'hA4, 1, 1, 4'b0000, "R11 non-header in 10-bit");
    sendByte(8'h00, 1, 1, 4'b1110, "R7 gc in 10-bit");

    // R8 stop together with a byte strobe
    sendByte(8'hF4, 1, 1, 4'b1000, "R4 header write");
    sendByte(8'hC5, 0, 1, 4'b1100, "R4 low byte match");
    @(negedge clk);
    byteData = 8'hF5; firstByte = 1'b1; byteValid = 1'b1; stopDet = 1'b1;
    @(negedge clk);
    byteValid = 1'b0; firstByte = 1'b0; stopDet = 1'b0;
    check(addressed === 1'b0, "R8 stop wins over byte", {3'b0, addressed}, 4'b0000);
    sendByte(8'hF5, 1, 1, 4'b0000, "R8 match forgotten");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1 all decisions seen", 4'(expQ.size()), 4'b0000);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule